// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter with Parking

This block decides which of up to sixteen masters owns a shared address bus. It also issues the matching data-bus grant after a transfer starts. A table of priority levels, loaded through a small register port, maps each level to a master index. Level 0 is the most urgent. On every clock the arbiter scans the levels from 0 upward and grants the address bus to the first master whose request is active. When no master listed in the table is requesting, the address grant goes to a parked master that software chooses. That master can then start a transfer without paying for an arbitration cycle.

A transfer-start pulse marks the beginning of an address tenure. The master holding the address grant in that cycle becomes the owner of the coming data tenure. A configuration bit picks the data-grant latency:
- With the bit clear, the grant is issued as early as possible.
- With the bit set, at least one wait cycle is enforced.

If the data bus is busy, the grant waits in a single pending slot until the bus frees up.

Top module: `arb_prio_park`

## Requirements
- R1: While `rst_i` is high, and in the cycle after it, both grant vectors are zero. Reset loads the tables as follows: level n holds master index n, the parked master is 2, and the delay bit is 0.
- R2: Register map on `reg_addr_i`:
  - Addresses 0 to 15 hold priority levels 0 to 15, with the master index in bits [3:0].
  - Address 16 is configuration, with the parked master in bits [3:0] and the delay bit in bit 4.
  - Any other address reads zero, and writes to it change nothing.
  - Reads are combinational. Writes take effect at the clock edge where `reg_we_i` is high.
- R3: Bits that carry no field (bits [7:4] of a level, bits [7:5] of the configuration) always read zero, whatever was written to them.
- R4: `abg_o` is registered. After the edge that samples `req_i`, it grants the master named by the lowest-numbered level whose master is requesting.
- R5: When two levels name the same master, the lower level decides that master's rank. A requesting master that no level names is never granted through the scan.
- R6: When no master named in the table is requesting, the next `abg_o` grants the parked master. The parked master value used is the one held before that edge.
- R7: `abg_o` and `dbg_o` each have at most one bit set at any time.
- R8: The data grant, `dbg_o`, is a one-cycle pulse to the master that held `abg_o` in the cycle of `ts_i`. This applies with the delay bit 0, no grant pending, and `dbusy_i` low in the `ts_i` cycle. The pulse appears in the cycle right after `ts_i`.
- R9: With the delay bit 1, no data grant appears in the cycle right after `ts_i`. The grant then becomes pending.
- R10: A pending data grant is held while `dbusy_i` is high. It is issued in the cycle after the first cycle in which `dbusy_i` is low.
- R11: A `ts_i` that arrives while a data grant is pending is ignored. The pending owner is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 16 | Bus request, one bit per master |
| abg_o | output | 16 | Address-bus grant, one-hot or zero |
| ts_i | input | 1 | Transfer-start pulse from the address-bus owner |
| dbusy_i | input | 1 | Data bus is still occupied |
| dbg_o | output | 16 | Data-bus grant pulse, one-hot or zero |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |

## Verification
Two things can land on the same edge: the address grant moving to a new master, and a data grant being issued or captured for the previous owner. This matters most with a pending grant released by `dbusy_i` falling. The bench provokes this by driving random requests, transfer starts and busy cycles together under both delay settings. It also rewrites the table and the parked master in mid-stream. A behavioural reference model predicts both grant vectors on every clock, and the design's outputs are compared against it. Under that model the data grant must still name the owner captured at `ts_i`, while the address grant follows the newest requests.

// File: rtl/arb_prio_pkg.sv
package arb_prio_pkg;
  typedef enum logic [0:0] {DG_IDLE = 1'b0, DG_WAIT = 1'b1} dg_state_e;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs #(
  parameter int NM = 16,
  parameter int IW = 4,
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int RST_PARK = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NM-1:0][IW-1:0]  tbl_o,
  output logic [IW-1:0]          park_o,
  output logic                   dly_o
);
  localparam logic [AW-1:0] CFG_ADDR = AW'(NM);

  logic [NM-1:0][IW-1:0] tbl_q;
  logic [IW-1:0]         park_q;
  logic                  dly_q;
  wire                   unused_wbits = ^wdata_i[DW-1:IW+1];

  // one storage slot per priority level, reset to its own level number
  for (genvar l = 0; l < NM; l++) begin : g_lvl
    always_ff @(posedge clk_i) begin
      if (rst_i)
        tbl_q[l] <= IW'(l);
      else if (we_i && addr_i == AW'(l))
        tbl_q[l] <= wdata_i[IW-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      park_q <= IW'(RST_PARK);
      dly_q  <= 1'b0;
    end else if (we_i && addr_i == CFG_ADDR) begin
      park_q <= wdata_i[IW-1:0];
      dly_q  <= wdata_i[IW];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < CFG_ADDR)
      rdata_o = DW'(tbl_q[addr_i[IW-1:0]]);
    else if (addr_i == CFG_ADDR)
      rdata_o = DW'({dly_q, park_q});
  end

  assign tbl_o  = tbl_q;
  assign park_o = park_q;
  assign dly_o  = dly_q;

  // R3: field-less bits never read back as one
  p_resv_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr_i < CFG_ADDR) |-> (rdata_o[DW-1:IW] == '0));
  p_cfg_resv_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr_i == CFG_ADDR) |-> (rdata_o[DW-1:IW+1] == '0));
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int NM = 16,
  parameter int IW = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic [NM-1:0]          req_i,
  input  logic [NM-1:0][IW-1:0]  tbl_i,
  input  logic [IW-1:0]          park_i,
  output logic [IW-1:0]          win_o,
  output logic                   hit_o
);
  // walk from the weakest level up so the strongest hit is written last
  always_comb begin
    win_o = park_i;
    hit_o = 1'b0;
    for (int l = NM - 1; l >= 0; l--) begin
      if (req_i[tbl_i[l]]) begin
        win_o = tbl_i[l];
        hit_o = 1'b1;
      end
    end
  end

  // R4: a scan hit always names a master that is requesting
  p_hit_is_req_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> req_i[win_o]);
  // R4: level 0's master, when requesting, always wins
  p_level0_wins_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    req_i[tbl_i[0]] |-> (win_o == tbl_i[0]));
endmodule

// File: rtl/arb_data_grant.sv
module arb_data_grant
  import arb_prio_pkg::*;
#(
  parameter int NM = 16,
  parameter int IW = 4
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           ts_i,
  input  logic           dbusy_i,
  input  logic           dly_i,
  input  logic [IW-1:0]  own_i,
  output logic [NM-1:0]  dbg_o,
  output logic           pend_o
);
  dg_state_e     st_q;
  logic [IW-1:0] pidx_q;
  logic [NM-1:0] dbg_q;
  logic          pend_w, go_now, go_late, issue;
  logic [IW-1:0] who;

  function automatic logic [NM-1:0] idx_to_oh(input logic [IW-1:0] i);
    idx_to_oh = '0;
    idx_to_oh[i] = 1'b1;
  endfunction

  assign pend_w  = (st_q == DG_WAIT);
  assign go_now  = ts_i && !pend_w && !dly_i && !dbusy_i;
  assign go_late = pend_w && !dbusy_i;
  assign issue   = go_now || go_late;
  assign who     = pend_w ? pidx_q : own_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= DG_IDLE;
      pidx_q <= '0;
      dbg_q  <= '0;
    end else begin
      dbg_q <= issue ? idx_to_oh(who) : '0;
      if (pend_w) begin
        if (!dbusy_i) st_q <= DG_IDLE;
      end else if (ts_i && !go_now) begin
        st_q   <= DG_WAIT;
        pidx_q <= own_i;
      end
    end
  end

  assign dbg_o  = dbg_q;
  assign pend_o = pend_w;

  p_dbg_onehot_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(dbg_o));
  p_fast_grant_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (ts_i && !pend_w && !dly_i && !dbusy_i) |=> (dbg_o == idx_to_oh($past(own_i))));
  p_min_wait_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (ts_i && !pend_w && dly_i) |=> (dbg_o == '0 && pend_w));
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend_w && dbusy_i) |=> (dbg_o == '0 && pend_w));
  p_keep_owner_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend_w && dbusy_i && ts_i) |=> (pidx_q == $past(pidx_q)));
endmodule

// File: rtl/arb_prio_park.sv
module arb_prio_park #(
  parameter int NM = 16,
  parameter int DW = 8,
  parameter int RST_PARK = 2,
  localparam int IW = $clog2(NM),
  localparam int AW = $clog2(NM + 1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [NM-1:0] req_i,
  output logic [NM-1:0] abg_o,
  input  logic          ts_i,
  input  logic          dbusy_i,
  output logic [NM-1:0] dbg_o,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o
);
  logic [NM-1:0][IW-1:0] tbl_w;
  logic [IW-1:0]         park_w, win_w, own_w;
  logic                  dly_w, hit_w, pend_w;
  logic [NM-1:0]         abg_q;

  function automatic logic [NM-1:0] idx_to_oh(input logic [IW-1:0] i);
    idx_to_oh = '0;
    idx_to_oh[i] = 1'b1;
  endfunction

  function automatic logic [IW-1:0] oh_to_idx(input logic [NM-1:0] v);
    oh_to_idx = '0;
    for (int i = 0; i < NM; i++)
      if (v[i]) oh_to_idx = oh_to_idx | IW'(i);
  endfunction

  arb_cfg_regs #(.NM(NM), .IW(IW), .AW(AW), .DW(DW), .RST_PARK(RST_PARK)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .tbl_o(tbl_w), .park_o(park_w), .dly_o(dly_w));

  arb_prio_pick #(.NM(NM), .IW(IW)) u_pick (
    .clk_i(clk_i), .rst_i(rst_i), .req_i(req_i), .tbl_i(tbl_w),
    .park_i(park_w), .win_o(win_w), .hit_o(hit_w));

  always_ff @(posedge clk_i) begin
    if (rst_i) abg_q <= '0;
    else       abg_q <= idx_to_oh(win_w);
  end

  assign abg_o = abg_q;
  assign own_w = oh_to_idx(abg_q);

  arb_data_grant #(.NM(NM), .IW(IW)) u_dgrant (
    .clk_i(clk_i), .rst_i(rst_i), .ts_i(ts_i), .dbusy_i(dbusy_i),
    .dly_i(dly_w), .own_i(own_w), .dbg_o(dbg_o), .pend_o(pend_w));

  wire unused_pend = pend_w;

  p_abg_onehot_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(abg_o));
  p_park_idle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!hit_w) |=> (abg_o == idx_to_oh($past(park_w))));
  p_scan_reg_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_w |=> abg_o[$past(win_w)]);
  p_post_reset_r1: assert property (@(posedge clk_i)
    rst_i |=> (abg_o == '0 && dbg_o == '0));
endmodule

// File: tb/sim_arb_prio_park.sv
module sim_arb_prio_park;
  localparam int NM = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] req;
  logic [15:0] abg, dbg;
  logic        ts, dbusy, we;
  logic [4:0]  addr;
  logic [7:0]  wdata, rdata;

  always #4 clk = ~clk;

  arb_prio_park u0 (
    .clk_i(clk), .rst_i(rst), .req_i(req), .abg_o(abg), .ts_i(ts),
    .dbusy_i(dbusy), .dbg_o(dbg), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata));

  int    total = 0, bad = 0;
  string tag = "R1";

  // behavioural reference state
  int          m_tbl[16];
  int          m_park, m_dly, m_pidx;
  bit          m_pend;
  logic [15:0] m_abg, m_dbg;

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic int m_read(int a);
    if (a < 16) return m_tbl[a];
    if (a == 16) return m_dly * 16 + m_park;
    return 0;
  endfunction

  task automatic model_edge();
    int cur, w;
    bit found;
    logic [15:0] nd;
    if (rst) begin
      for (int i = 0; i < 16; i++) m_tbl[i] = i;
      m_park = 2; m_dly = 0; m_pend = 0; m_pidx = 0;
      m_abg = '0; m_dbg = '0;
      return;
    end
    cur = 0;
    for (int i = 0; i < 16; i++) if (m_abg[i]) cur = i;
    w = m_park; found = 0;
    for (int l = 0; l < 16; l++)
      if (!found && req[m_tbl[l]]) begin w = m_tbl[l]; found = 1; end
    nd = '0;
    if (m_pend) begin
      if (!dbusy) begin nd = 16'(1) << m_pidx; m_pend = 0; end
    end else if (ts) begin
      if (m_dly == 0 && !dbusy) nd = 16'(1) << cur;
      else begin m_pend = 1; m_pidx = cur; end
    end
    m_abg = 16'(1) << w;
    m_dbg = nd;
    if (we) begin
      if (addr < 16) m_tbl[addr] = wdata & 8'h0f;
      else if (addr == 16) begin m_park = wdata & 8'h0f; m_dly = wdata[4]; end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
    chk(tag, "abg", 32'(abg), 32'(m_abg));
    chk(tag, "dbg", 32'(dbg), 32'(m_dbg));
  endtask

  task automatic wr(int a, int d);
    we = 1'b1; addr = 5'(a); wdata = 8'(d);
    cyc();
    we = 1'b0;
  endtask

  task automatic rd(int a);
    addr = 5'(a);
    #1;
    chk(tag, "rdata", 32'(rdata), 32'(m_read(a)));
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req = '0; ts = 1'b0; dbusy = 1'b0;
    we = 1'b0; addr = '0; wdata = '0;
    tag = "R1";
    repeat (3) cyc();
    rst = 1'b0;
    for (int a = 0; a < 17; a++) rd(a);

    tag = "R2";
    rd(20); rd(31);
    wr(20, 8'h5a); rd(20);
    for (int a = 0; a < 17; a++) rd(a);

    tag = "R6";
    repeat (3) cyc();
    wr(16, 8'h07);
    repeat (2) cyc();

    tag = "R4";
    for (int i = 0; i < 40; i++) begin req = 16'($urandom); cyc(); end
    req = 16'h8001; cyc(); cyc();
    req = '0;

    tag = "R5";
    wr(0, 5); wr(1, 5); wr(2, 3); wr(15, 0);
    req = 16'h0028; cyc(); cyc();
    req = 16'h8000; cyc(); cyc();
    req = 16'h0009; cyc(); cyc();
    req = '0;

    tag = "R3";
    wr(3, 8'hff); rd(3);
    wr(16, 8'hff); rd(16);
    wr(16, 8'h02); rd(16);

    tag = "R8";
    req = 16'h0200; cyc(); cyc();
    ts = 1'b1; cyc(); ts = 1'b0; cyc(); cyc();

    tag = "R10";
    dbusy = 1'b1; ts = 1'b1; cyc(); ts = 1'b0;
    repeat (3) cyc();
    dbusy = 1'b0; cyc(); cyc();

    tag = "R9";
    wr(16, 8'h12);
    ts = 1'b1; cyc(); ts = 1'b0; cyc(); cyc();
    ts = 1'b1; dbusy = 1'b1; cyc(); ts = 1'b0; cyc();
    dbusy = 1'b0; cyc(); cyc();

    tag = "R11";
    dbusy = 1'b1; ts = 1'b1; cyc();
    req = 16'h0010; cyc(); cyc();
    ts = 1'b1; cyc(); ts = 1'b0; cyc();
    dbusy = 1'b0; cyc(); cyc();

    tag = "R7";
    for (int i = 0; i < 300; i++) begin
      req   = 16'($urandom) & 16'($urandom);
      ts    = ($urandom % 3) == 0;
      dbusy = ($urandom % 4) == 0;
      if (i % 50 == 25) wr(16, int'($urandom % 32));
      else if (i % 37 == 0) wr(int'($urandom % 16), int'($urandom % 16));
      else cyc();
    end
    ts = 1'b0; dbusy = 1'b0; req = '0;
    repeat (3) cyc();

    tag = "R1";
    rst = 1'b1; cyc(); cyc(); rst = 1'b0;
    for (int a = 0; a < 17; a++) rd(a);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule